// File: doc/BRIEF.md
# Programmable Phase Frequency Detector

This block is the digital comparison stage of an integer-N synthesizer loop. It watches two clocks that have already been divided down, the reference and the oscillator feedback, and compares their rising edges in both frequency and phase. Its output is a pair of pump-control pulses. A reference edge opens a "raise" request and a feedback edge opens a "lower" request. Once both requests are open, they are held together for a short programmed overlap and then both are closed. This overlap removes the dead zone of the pump that follows the detector.

Both divided clocks are assumed to be synchronous to a fast sampling clock, so every timing is counted in fast-clock cycles. A polarity input swaps the two pump controls, so the same detector can steer an oscillator whose tuning gain is positive or negative. A high-impedance command parks the pump, and a test enable exposes the raw internal requests. A lock indicator reports when the loop has stayed aligned over a run of comparisons.

Top module: `pfd_pump_ctrl`

## Requirements
- R1: During and immediately after a synchronous active-low reset, pump_up, pump_dn, tst_up, tst_dn and locked are all 0. pump_hiz is 0 as long as hiz_cmd is 0.
- R2: The edge detectors sample ref_div and fb_div every cycle. A 0-to-1 change of ref_div opens the internal raise request from the next clock edge, and a 0-to-1 change of fb_div opens the lower request from the next clock edge. A request that is open stays open until an overlap completes, even if more edges arrive on the same input.
- R3: Once both requests are open, they stay open together for exactly N cycles and then both close at the same time. N depends on ovl_sel: 2'b00 gives 3 cycles, 2'b01 gives 2, 2'b10 gives 8 and 2'b11 gives 6.
- R4: When pol_pos is 1, pump_up carries the raise request and pump_dn carries the lower request. When pol_pos is 0, the two are swapped.
- R5: An input edge that arrives while both requests are open is held. The matching request reopens in the cycle after the overlap closes, so the edge is not lost.
- R6: While hiz_cmd is 1, pump_up and pump_dn are 0 and pump_hiz is 1, whatever the detector state. The detector keeps running underneath.
- R7: When tst_en is 1, tst_up and tst_dn show the raw raise and lower requests, before the polarity swap and before high-impedance parking. When tst_en is 0, both are 0.
- R8: A comparison ends when an overlap closes. It counts as good when the number of cycles in which exactly one request was open stayed at or below LOCK_TOL (default 2). locked goes to 1 after 16 good comparisons in a row, and any bad comparison returns it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_div | input | 1 | Divided reference clock |
| fb_div | input | 1 | Divided feedback clock |
| ovl_sel | input | 2 | Overlap width select |
| pol_pos | input | 1 | 1 = positive oscillator gain, 0 = swap pump controls |
| hiz_cmd | input | 1 | Park the pump in high impedance |
| tst_en | input | 1 | Expose raw requests on the test pins |
| pump_up | output | 1 | Pump raise control |
| pump_dn | output | 1 | Pump lower control |
| pump_hiz | output | 1 | Pump high-impedance flag |
| tst_up | output | 1 | Raw raise request when test is enabled |
| tst_dn | output | 1 | Raw lower request when test is enabled |
| locked | output | 1 | Lock indicator |

## Verification
The detector is driven with several input patterns, and each one isolates a different behaviour:

- Aligned clocks of equal period isolate the overlap width for every ovl_sel setting and build up lock.
- A phase lead on either side separates the raise path from the lower path, and a lag beyond the tolerance shows that lock is dropped.
- A reference much faster than the feedback shows that repeated edges are absorbed by an open request, and that edges arriving inside a long overlap are held rather than lost.
- Runs with the polarity bit, the park command and the test enable toggled show that each one changes only its own outputs.

// File: rtl/pfd_pkg.sv
// Package: shared constants and the overlap-width decode for the detector.
package pfd_pkg;
    localparam int OVL_MAX   = 8;  // longest overlap in cycles
    localparam int OVL_W     = 4;  // width of the overlap counter
    localparam int NUM_CH    = 2;  // channel 0 = reference, 1 = feedback
    localparam int CH_REF    = 0;
    localparam int CH_FB     = 1;

    // Decode the 2-bit overlap select into a cycle count.
    function automatic logic [OVL_W-1:0] ovl_cycles(input logic [1:0] sel);
        case (sel)
            2'b00:   ovl_cycles = OVL_W'(3);
            2'b01:   ovl_cycles = OVL_W'(2);
            2'b10:   ovl_cycles = OVL_W'(8);
            default: ovl_cycles = OVL_W'(6);
        endcase
    endfunction
endpackage

// File: rtl/pfd_edge.sv
// Module: rising-edge detector for one divided clock.
// Assumes the input is already synchronous to clk. The output pulses in the
// same cycle the input is first seen high after having been seen low.
module pfd_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    // Remember last cycle's sample; cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_in;
    end

    // A rise is high now and low on the previous sample.
    assign rise = sig_in & ~prev_q;
endmodule

// File: rtl/pfd_core.sv
// Module: tri-state detector core holding the raise/lower requests.
// Assumes single-cycle edge strobes. Once both requests are open it counts
// the programmed overlap and then closes both. Edges that arrive inside the
// overlap are held and reopen their request when it closes.
module pfd_core
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise,
    input  logic       fb_rise,
    input  logic [1:0] ovl_sel,
    output logic       req_up,
    output logic       req_dn,
    output logic       clr,
    output logic       one_side
);
    logic             up_q, dn_q, pend_up, pend_dn;
    logic [OVL_W-1:0] ovl_cnt, ovl_lim;
    logic             both;

    assign ovl_lim  = ovl_cycles(ovl_sel);
    assign both     = up_q & dn_q;
    assign clr      = both && (ovl_cnt >= ovl_lim - OVL_W'(1));
    assign one_side = up_q ^ dn_q;

    // Request, held-edge and overlap-count state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q    <= 1'b0;
            dn_q    <= 1'b0;
            pend_up <= 1'b0;
            pend_dn <= 1'b0;
            ovl_cnt <= '0;
        end else if (both) begin
            if (clr) begin
                up_q    <= pend_up | ref_rise;
                dn_q    <= pend_dn | fb_rise;
                pend_up <= 1'b0;
                pend_dn <= 1'b0;
                ovl_cnt <= '0;
            end else begin
                pend_up <= pend_up | ref_rise;
                pend_dn <= pend_dn | fb_rise;
                ovl_cnt <= ovl_cnt + OVL_W'(1);
            end
        end else begin
            up_q    <= up_q | ref_rise;
            dn_q    <= dn_q | fb_rise;
            ovl_cnt <= '0;
        end
    end

    assign req_up = up_q;
    assign req_dn = dn_q;
endmodule

// File: rtl/pfd_lock.sv
// Module: lock qualifier.
// Counts the one-sided cycles in each comparison and judges the comparison
// when the overlap closes. After RUNS good comparisons in a row it raises
// locked; any bad comparison clears it.
module pfd_lock #(
    parameter int RUNS = 16,
    parameter int TOL  = 2,
    parameter int LAG_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic one_side,
    input  logic clr,
    output logic locked
);
    localparam int RUN_W   = $clog2(RUNS + 1);
    localparam int LAG_MAX = (1 << LAG_W) - 1;

    logic [LAG_W-1:0] lag_cnt;
    logic [RUN_W-1:0] run_cnt;
    logic             good;

    assign good = (int'(lag_cnt) <= TOL);

    // Saturating count of one-sided cycles, restarted at each close.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  lag_cnt <= '0;
        else if (clr)                                lag_cnt <= '0;
        else if (one_side && int'(lag_cnt) < LAG_MAX) lag_cnt <= lag_cnt + LAG_W'(1);
    end

    // Run of consecutive good comparisons, saturating at RUNS.
    always_ff @(posedge clk) begin
        if (!rst_n) run_cnt <= '0;
        else if (clr) begin
            if (!good)                     run_cnt <= '0;
            else if (int'(run_cnt) < RUNS) run_cnt <= run_cnt + RUN_W'(1);
        end
    end

    assign locked = (int'(run_cnt) == RUNS);
endmodule

// File: rtl/pfd_pump_ctrl.sv
// Module: top of the programmable phase frequency detector.
// Assumes ref_div and fb_div are synchronous to clk. It builds edge
// detectors for both inputs, the detector core and the lock qualifier, then
// applies the polarity swap, high-impedance parking and test exposure.
module pfd_pump_ctrl #(
    parameter int LOCK_RUNS = 16,
    parameter int LOCK_TOL  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_div,
    input  logic       fb_div,
    input  logic [1:0] ovl_sel,
    input  logic       pol_pos,
    input  logic       hiz_cmd,
    input  logic       tst_en,
    output logic       pump_up,
    output logic       pump_dn,
    output logic       pump_hiz,
    output logic       tst_up,
    output logic       tst_dn,
    output logic       locked
);
    import pfd_pkg::*;

    logic [NUM_CH-1:0] ch_in, ch_rise;
    logic              req_up, req_dn, clr, one_side;
    logic              sw_up, sw_dn;

    assign ch_in[CH_REF] = ref_div;
    assign ch_in[CH_FB]  = fb_div;

    // One edge detector for each compared clock.
    for (genvar g = 0; g < NUM_CH; g++) begin : g_edge
        pfd_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_in (ch_in[g]),
            .rise   (ch_rise[g])
        );
    end

    pfd_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ch_rise[CH_REF]),
        .fb_rise  (ch_rise[CH_FB]),
        .ovl_sel  (ovl_sel),
        .req_up   (req_up),
        .req_dn   (req_dn),
        .clr      (clr),
        .one_side (one_side)
    );

    pfd_lock #(.RUNS(LOCK_RUNS), .TOL(LOCK_TOL)) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .one_side (one_side),
        .clr      (clr),
        .locked   (locked)
    );

    // Polarity swap, then parking of the pump when high impedance is asked.
    always_comb begin
        sw_up   = pol_pos ? req_up : req_dn;
        sw_dn   = pol_pos ? req_dn : req_up;
        pump_up = sw_up & ~hiz_cmd;
        pump_dn = sw_dn & ~hiz_cmd;
    end

    assign pump_hiz = hiz_cmd;
    assign tst_up   = tst_en & req_up;
    assign tst_dn   = tst_en & req_dn;
endmodule

// File: rtl/pfd_pump_ctrl_chk.sv
// Module: property checker bound to the detector top.
module pfd_pump_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic ref_div,
    input logic fb_div,
    input logic pol_pos,
    input logic hiz_cmd,
    input logic tst_en,
    input logic pump_up,
    input logic pump_dn,
    input logic pump_hiz,
    input logic tst_up,
    input logic tst_dn,
    input logic locked,
    input logic req_up,
    input logic req_dn,
    input logic clr
);
    import pfd_pkg::*;
    int unsigned both_run;

    // Length of the current run of cycles with both requests open.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || !(req_up && req_dn)) both_run <= 0;
        else                                       both_run <= both_run + 1;
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!req_up && !req_dn && !locked));
    a_r2_ref_opens: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ref_div) |=> req_up);
    a_r2_fb_opens: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fb_div) |=> req_dn);
    a_r3_window_max: assert property (@(posedge clk) disable iff (!rst_n)
        both_run < OVL_MAX);
    a_r4_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_en && !hiz_cmd && !pol_pos) |-> (pump_up == tst_dn && pump_dn == tst_up));
    a_r6_parked: assert property (@(posedge clk) disable iff (!rst_n)
        hiz_cmd |-> (pump_hiz && !pump_up && !pump_dn));
    a_r8_lock_on_close: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(clr));
endmodule

bind pfd_pump_ctrl pfd_pump_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_div  (ref_div),
    .fb_div   (fb_div),
    .pol_pos  (pol_pos),
    .hiz_cmd  (hiz_cmd),
    .tst_en   (tst_en),
    .pump_up  (pump_up),
    .pump_dn  (pump_dn),
    .pump_hiz (pump_hiz),
    .tst_up   (tst_up),
    .tst_dn   (tst_dn),
    .locked   (locked),
    .req_up   (req_up),
    .req_dn   (req_dn),
    .clr      (clr)
);

// File: tb/pfd_pump_ctrl_tb.sv
module pfd_pump_ctrl_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_div = 1'b0, fb_div = 1'b0;
    logic [1:0] ovl_sel = 2'b00;
    logic pol_pos = 1'b1, hiz_cmd = 1'b0, tst_en = 1'b1;
    logic pump_up, pump_dn, pump_hiz, tst_up, tst_dn, locked;

    int total = 0, bad = 0, cyc = 0;
    string cur_req = "R1";

    // Reference model state
    bit m_up, m_dn, m_pu, m_pd, m_rq, m_fq;
    int m_cnt, m_lag, m_run;

    // Directed measurement state
    int  both_len = 0;
    bit  measure = 0;
    int  exp_n = 0;

    always #2 clk = ~clk;

    pfd_pump_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ref_div(ref_div), .fb_div(fb_div),
        .ovl_sel(ovl_sel), .pol_pos(pol_pos), .hiz_cmd(hiz_cmd), .tst_en(tst_en),
        .pump_up(pump_up), .pump_dn(pump_dn), .pump_hiz(pump_hiz),
        .tst_up(tst_up), .tst_dn(tst_dn), .locked(locked)
    );

    function automatic int ovl_n(input logic [1:0] s);
        case (s)
            2'b00: return 3;
            2'b01: return 2;
            2'b10: return 8;
            default: return 6;
        endcase
    endfunction

    // Behavioural model: advance one clock.
    always @(posedge clk) begin
        bit rr, fr;
        if (!rst_n) begin
            m_up = 0; m_dn = 0; m_pu = 0; m_pd = 0; m_rq = 0; m_fq = 0;
            m_cnt = 0; m_lag = 0; m_run = 0;
        end else begin
            rr = ref_div && !m_rq;
            fr = fb_div && !m_fq;
            m_rq = ref_div; m_fq = fb_div;
            if (m_up && m_dn) begin
                if (m_cnt >= ovl_n(ovl_sel) - 1) begin
                    if (m_lag <= 2) m_run = (m_run < 16) ? m_run + 1 : 16;
                    else            m_run = 0;
                    m_lag = 0;
                    m_up = m_pu || rr; m_dn = m_pd || fr;
                    m_pu = 0; m_pd = 0; m_cnt = 0;
                end else begin
                    m_cnt++;
                    m_pu = m_pu || rr; m_pd = m_pd || fr;
                end
            end else begin
                if ((m_up != m_dn) && m_lag < 255) m_lag++;
                m_up = m_up || rr; m_dn = m_dn || fr;
                m_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", req, what, cyc, act, exp);
        end
    endtask

    // Compare every output against the model.
    task automatic compare_all();
        bit eu, ed;
        eu = pol_pos ? m_up : m_dn;
        ed = pol_pos ? m_dn : m_up;
        chk(cur_req, "pump_up R4", pump_up, (eu && !hiz_cmd));
        chk(cur_req, "pump_dn R4", pump_dn, (ed && !hiz_cmd));
        chk("R6", "pump_hiz", pump_hiz, hiz_cmd);
        chk("R7", "tst_up", tst_up, (tst_en && m_up));
        chk("R7", "tst_dn", tst_dn, (tst_en && m_dn));
        chk("R8", "locked", locked, (rst_n && m_run == 16));
        if (measure) begin
            if (tst_up && tst_dn) both_len++;
            else if (both_len != 0) begin
                chk("R3", "overlap width", both_len, exp_n);
                both_len = 0;
            end
        end
    endtask

    // Drive clocks with given periods and feedback offset for n cycles.
    task automatic run(input int rp, input int fp, input int off, input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            ref_div = ((t % rp) < rp / 2);
            fb_div  = (((t + off) % fp) < fp / 2);
            #1;
            cyc++;
            compare_all();
        end
    endtask

    task automatic idle(input int n);
        for (int t = 0; t < n; t++) begin
            @(negedge clk);
            ref_div = 0; fb_div = 0;
            #1; cyc++;
            compare_all();
        end
    endtask

    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired at cycle %0d: actual=hung expected=done", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); ref_div = 1; fb_div = 1; #1; cyc++; compare_all();
        end
        chk("R1", "pump_up in reset", pump_up, 0);
        chk("R1", "locked in reset", locked, 0);
        @(negedge clk); rst_n = 1; ref_div = 0; fb_div = 0;
        #1; cyc++; compare_all();
        chk("R1", "tst_up after reset", tst_up, 0);

        // R3 and R8: aligned clocks for every overlap width
        for (int s = 0; s < 4; s++) begin
            ovl_sel = s[1:0];
            exp_n = ovl_n(ovl_sel);
            measure = 1; both_len = 0;
            cur_req = "R3";
            run(20, 20, 0, 400);
            measure = 0;
            idle(12);
            chk("R8", "locked after aligned run", locked, 1);
        end

        // R2 and R8: reference leads by 5 cycles, lock must drop
        ovl_sel = 2'b00;
        cur_req = "R2";
        run(20, 20, 15, 200);
        chk("R8", "locked with large lag", locked, 0);

        // R4: polarity swapped with the feedback leading
        pol_pos = 0; cur_req = "R4";
        run(20, 20, 3, 200);
        pol_pos = 1;

        // R2: reference much faster than feedback
        cur_req = "R2";
        run(4, 40, 0, 200);

        // R5: edges arriving inside a long overlap
        ovl_sel = 2'b10; cur_req = "R5";
        run(4, 12, 1, 300);
        run(6, 6, 2, 200);

        // R6 and R7: park the pump, test off
        hiz_cmd = 1; tst_en = 0; cur_req = "R6";
        run(20, 20, 2, 100);
        chk("R6", "pump_up parked", pump_up, 0);
        hiz_cmd = 0; cur_req = "R7";
        run(20, 20, 18, 100);
        tst_en = 1;
        run(20, 20, 0, 100);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule